// File: doc/BRIEF.md
# Fine Phase Step Sequencer

This block drives the dynamic fine phase adjustment port of a clock synthesizer. A caller asks for a number of phase steps in one direction with a single start pulse. The block then issues the steps one at a time. Each step is a one-cycle enable pulse, with a direction level beside it. After each pulse the block waits for the single-cycle done pulse that the synthesizer returns, and only then issues the next step. All logic runs in the phase adjustment clock domain.

A step is 1/(56·Fvco) long. With a 960 MHz VCO that is about 18.6 ps, so a request of 163 increment steps moves the output by roughly 3 ns. The block keeps a signed running count of the steps that have been acknowledged. A watchdog catches a synthesizer that never answers. A sticky error flag records a missing or stray done pulse. The step request can be given as magnitude plus direction (the default) or as one two's-complement count; a parameter selects the form.

Top module: `phase_step_seq`

## Requirements
- R1: `ps_en_o` is high for exactly one clock cycle per step and is never high in two consecutive cycles.
- R2: `ps_incdec_o` is 1 for an increment step and 0 for a decrement step. In magnitude mode it takes the `step_dir_i` value captured with the accepted start. It holds that value for the whole time `busy_o` is high.
- R3: An accepted request with count N > 0 produces exactly N enable pulses, all in the requested direction. This includes a 163-step request.
- R4: After an enable pulse, no further enable is issued until a done pulse has been sampled. A 12-cycle enable-to-done latency is handled with no error.
- R5: `complete_o` is high for one cycle, on the second rising edge after the final done pulse is sampled. `busy_o` falls on that same edge.
- R6: A start with count 0 raises `complete_o` on the next edge for one cycle. It produces no enable pulse and leaves `busy_o` low.
- R7: `position_o` (two's complement) changes by +1 for each acknowledged increment step and by -1 for each acknowledged decrement step. It changes only on an edge where done is sampled during a wait.
- R8: If done does not arrive within TMO_CYC cycles of waiting, the sequence aborts. `error_o` is then set and stays set, `busy_o` falls, no complete pulse is given and no further enable is issued.
- R9: A start that arrives while `busy_o` is high is ignored. The pulse count and final position reflect only the request already running.
- R10: A done pulse that arrives while no step is outstanding sets `error_o` and leaves `position_o` unchanged.
- R11: Synchronous active-high `rst` clears `error_o`, `position_o` and `busy_o`, and holds `ps_en_o` low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Phase adjustment clock |
| rst | input | 1 | Synchronous active-high reset |
| start_i | input | 1 | Request pulse, sampled when idle |
| step_cnt_i | input | CNT_W | Step count: magnitude, or two's complement in signed mode |
| step_dir_i | input | 1 | Direction in magnitude mode (1 = increment) |
| ps_done_i | input | 1 | Single-cycle acknowledge from the synthesizer |
| ps_en_o | output | 1 | One-cycle step enable |
| ps_incdec_o | output | 1 | Step direction, valid with the enable |
| busy_o | output | 1 | A request is in progress |
| complete_o | output | 1 | One-cycle completion pulse |
| error_o | output | 1 | Sticky timeout or stray-done flag |
| position_o | output | POS_W | Signed count of acknowledged steps |

## Verification
Two events can fall in the same cycle and both must be handled correctly. One is a start request that arrives during a running sequence, at the same moment as that sequence's own enable and done traffic. The other is a done pulse that the sequencer did not ask for. The bench fires a second start with the opposite direction in the middle of a 20-step run, and a scoreboard of expected step directions then judges that no extra enable and no direction change occurred. A stray done is injected while idle, and the test confirms that the error flag rises while the position counter stays where it was.

// File: rtl/pss_pkg.sv
package pss_pkg;

   typedef enum logic [1:0] {
      ST_IDLE  = 2'd0,
      ST_PULSE = 2'd1,
      ST_WAIT  = 2'd2,
      ST_NEXT  = 2'd3
   } pss_state_e;

endpackage

// File: rtl/pss_req_decode.sv
module pss_req_decode #(
   parameter int CNT_W      = 10,
   parameter bit SIGNED_REQ = 1'b0
) (
   input  logic [CNT_W-1:0] cnt_i,
   input  logic             dir_i,
   output logic [CNT_W-1:0] mag_o,
   output logic             inc_o,
   output logic             zero_o
);

   generate
      if (SIGNED_REQ) begin : g_signed
         logic neg;
         assign neg   = cnt_i[CNT_W-1];
         assign mag_o = neg ? (~cnt_i + CNT_W'(1)) : cnt_i;
         assign inc_o = ~neg;
      end else begin : g_magnitude
         assign mag_o = cnt_i;
         assign inc_o = dir_i;
      end
   endgenerate

   assign zero_o = (cnt_i == '0);

endmodule

// File: rtl/pss_wait_timer.sv
module pss_wait_timer #(
   parameter int TMO_CYC = 64
) (
   input  logic clk,
   input  logic rst,
   input  logic run_i,
   output logic expire_o
);

   localparam int TW = $clog2(TMO_CYC);

   logic [TW-1:0] cnt_q;

   always_ff @(posedge clk) begin
      if (rst || !run_i) begin
         cnt_q <= '0;
      end else if (cnt_q != TW'(TMO_CYC - 1)) begin
         cnt_q <= cnt_q + TW'(1);
      end
   end

   assign expire_o = run_i && (cnt_q == TW'(TMO_CYC - 1));

endmodule

// File: rtl/pss_position.sv
module pss_position #(
   parameter int POS_W = 16
) (
   input  logic             clk,
   input  logic             rst,
   input  logic             step_ok_i,
   input  logic             inc_i,
   output logic [POS_W-1:0] pos_o
);

   logic [POS_W-1:0] pos_q;

   always_ff @(posedge clk) begin
      if (rst) begin
         pos_q <= '0;
      end else if (step_ok_i) begin
         pos_q <= inc_i ? (pos_q + POS_W'(1)) : (pos_q - POS_W'(1));
      end
   end

   assign pos_o = pos_q;

endmodule

// File: rtl/pss_ctrl.sv
module pss_ctrl
   import pss_pkg::*;
#(
   parameter int CNT_W = 10
) (
   input  logic             clk,
   input  logic             rst,
   input  logic             start_i,
   input  logic [CNT_W-1:0] mag_i,
   input  logic             inc_i,
   input  logic             zero_i,
   input  logic             done_i,
   input  logic             expire_i,
   output logic             ps_en_o,
   output logic             incdec_o,
   output logic             busy_o,
   output logic             complete_o,
   output logic             error_o,
   output logic             waiting_o,
   output logic             step_ok_o
);

   pss_state_e       state_q;
   logic [CNT_W-1:0] rem_q;
   logic             dir_q;
   logic             complete_q;
   logic             error_q;

   always_ff @(posedge clk) begin
      if (rst) begin
         state_q    <= ST_IDLE;
         rem_q      <= '0;
         dir_q      <= 1'b0;
         complete_q <= 1'b0;
         error_q    <= 1'b0;
      end else begin
         complete_q <= 1'b0;
         if (done_i && (state_q != ST_WAIT)) begin
            error_q <= 1'b1;
         end
         case (state_q)
            ST_IDLE: begin
               if (start_i) begin
                  if (zero_i) begin
                     complete_q <= 1'b1;
                  end else begin
                     rem_q   <= mag_i;
                     dir_q   <= inc_i;
                     state_q <= ST_PULSE;
                  end
               end
            end
            ST_PULSE: begin
               state_q <= ST_WAIT;
            end
            ST_WAIT: begin
               if (done_i) begin
                  rem_q   <= rem_q - CNT_W'(1);
                  state_q <= ST_NEXT;
               end else if (expire_i) begin
                  error_q <= 1'b1;
                  state_q <= ST_IDLE;
               end
            end
            ST_NEXT: begin
               if (rem_q == '0) begin
                  complete_q <= 1'b1;
                  state_q    <= ST_IDLE;
               end else begin
                  state_q <= ST_PULSE;
               end
            end
            default: state_q <= ST_IDLE;
         endcase
      end
   end

   assign ps_en_o    = (state_q == ST_PULSE);
   assign incdec_o   = dir_q;
   assign busy_o     = (state_q != ST_IDLE);
   assign complete_o = complete_q;
   assign error_o    = error_q;
   assign waiting_o  = (state_q == ST_WAIT);
   assign step_ok_o  = (state_q == ST_WAIT) && done_i;

endmodule

// File: rtl/phase_step_seq.sv
module phase_step_seq #(
   parameter int CNT_W      = 10,
   parameter int POS_W      = 16,
   parameter int TMO_CYC    = 64,
   parameter bit SIGNED_REQ = 1'b0
) (
   input  logic             clk,
   input  logic             rst,
   input  logic             start_i,
   input  logic [CNT_W-1:0] step_cnt_i,
   input  logic             step_dir_i,
   input  logic             ps_done_i,
   output logic             ps_en_o,
   output logic             ps_incdec_o,
   output logic             busy_o,
   output logic             complete_o,
   output logic             error_o,
   output logic [POS_W-1:0] position_o
);

   generate
      if (CNT_W < 2) begin : g_bad_cnt
         $error("phase_step_seq: CNT_W must be at least 2");
      end
      if (POS_W < CNT_W + 1) begin : g_bad_pos
         $error("phase_step_seq: POS_W must exceed CNT_W");
      end
      if (TMO_CYC < 16) begin : g_bad_tmo
         $error("phase_step_seq: TMO_CYC must cover the 12-cycle handshake");
      end
   endgenerate

   logic [CNT_W-1:0] mag;
   logic             inc;
   logic             zero;
   logic             waiting;
   logic             expire;
   logic             step_ok;

   pss_req_decode #(
      .CNT_W      (CNT_W),
      .SIGNED_REQ (SIGNED_REQ)
   ) i_decode (
      .cnt_i  (step_cnt_i),
      .dir_i  (step_dir_i),
      .mag_o  (mag),
      .inc_o  (inc),
      .zero_o (zero)
   );

   pss_ctrl #(
      .CNT_W (CNT_W)
   ) i_ctrl (
      .clk        (clk),
      .rst        (rst),
      .start_i    (start_i),
      .mag_i      (mag),
      .inc_i      (inc),
      .zero_i     (zero),
      .done_i     (ps_done_i),
      .expire_i   (expire),
      .ps_en_o    (ps_en_o),
      .incdec_o   (ps_incdec_o),
      .busy_o     (busy_o),
      .complete_o (complete_o),
      .error_o    (error_o),
      .waiting_o  (waiting),
      .step_ok_o  (step_ok)
   );

   pss_wait_timer #(
      .TMO_CYC (TMO_CYC)
   ) i_timer (
      .clk      (clk),
      .rst      (rst),
      .run_i    (waiting),
      .expire_o (expire)
   );

   pss_position #(
      .POS_W (POS_W)
   ) i_pos (
      .clk       (clk),
      .rst       (rst),
      .step_ok_i (step_ok),
      .inc_i     (ps_incdec_o),
      .pos_o     (position_o)
   );

endmodule

// File: rtl/pss_checker.sv
module pss_checker #(
   parameter int POS_W = 16
) (
   input logic             clk,
   input logic             rst,
   input logic             ps_done_i,
   input logic             ps_en_o,
   input logic             ps_incdec_o,
   input logic             busy_o,
   input logic             complete_o,
   input logic             error_o,
   input logic [POS_W-1:0] position_o
);

   logic outstanding;

   always_ff @(posedge clk) begin
      if (rst) begin
         outstanding <= 1'b0;
      end else if (ps_en_o) begin
         outstanding <= 1'b1;
      end else if (ps_done_i || !busy_o) begin
         outstanding <= 1'b0;
      end
   end

   AST_EN_SINGLE: assert property (@(posedge clk) disable iff (rst)
      ps_en_o |=> !ps_en_o); // R1

   AST_DIR_HOLD: assert property (@(posedge clk) disable iff (rst)
      (busy_o && $past(busy_o)) |-> $stable(ps_incdec_o)); // R2

   AST_EN_AFTER_DONE: assert property (@(posedge clk) disable iff (rst)
      ps_en_o |-> !outstanding); // R4

   AST_COMPLETE_SINGLE: assert property (@(posedge clk) disable iff (rst)
      complete_o |=> !complete_o); // R5

   AST_POS_ON_DONE: assert property (@(posedge clk) disable iff (rst)
      !ps_done_i |=> $stable(position_o)); // R7

   AST_ERR_STICKY: assert property (@(posedge clk) disable iff (rst)
      error_o |=> error_o); // R8

   AST_RESET_CLEAN: assert property (@(posedge clk)
      rst |=> (!ps_en_o && !busy_o && !error_o && (position_o == '0))); // R11

endmodule

bind phase_step_seq pss_checker #(
   .POS_W (POS_W)
) i_pss_checker (
   .clk         (clk),
   .rst         (rst),
   .ps_done_i   (ps_done_i),
   .ps_en_o     (ps_en_o),
   .ps_incdec_o (ps_incdec_o),
   .busy_o      (busy_o),
   .complete_o  (complete_o),
   .error_o     (error_o),
   .position_o  (position_o)
);

// File: tb/test_phase_step_seq.sv
module test_phase_step_seq;

   localparam int CNT_W   = 10;
   localparam int POS_W   = 16;
   localparam int TMO_CYC = 64;
   localparam int LAT     = 12;

   logic             clk = 1'b0;
   logic             rst;
   logic             start_i;
   logic [CNT_W-1:0] step_cnt_i;
   logic             step_dir_i;
   logic             ps_done_i;
   logic             ps_en_o;
   logic             ps_incdec_o;
   logic             busy_o;
   logic             complete_o;
   logic             error_o;
   logic [POS_W-1:0] position_o;

   logic       resp_on;
   logic       resp_done;
   logic       inj_done;
   logic       pend;
   int         cd;

   int  n_chk  = 0;
   int  n_fail = 0;
   int  en_cnt = 0;
   int  cmp_cnt = 0;
   int  cyc    = 0;
   bit  exp_q[$];
   bit  zero_mode;
   logic en_prev;
   logic done_prev;
   logic cmp_prev;
   int   exp_pos;

   always #4 clk = ~clk;

   assign ps_done_i = resp_done | inj_done;

   phase_step_seq #(
      .CNT_W   (CNT_W),
      .POS_W   (POS_W),
      .TMO_CYC (TMO_CYC)
   ) i_phase_step_seq (
      .clk         (clk),
      .rst         (rst),
      .start_i     (start_i),
      .step_cnt_i  (step_cnt_i),
      .step_dir_i  (step_dir_i),
      .ps_done_i   (ps_done_i),
      .ps_en_o     (ps_en_o),
      .ps_incdec_o (ps_incdec_o),
      .busy_o      (busy_o),
      .complete_o  (complete_o),
      .error_o     (error_o),
      .position_o  (position_o)
   );

   task automatic check(input bit ok, input string req, input string what,
                        input int act, input int exp);
      n_chk++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
      end
   endtask

   task automatic summary();
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   endtask

   // done responder: answers each enable after a fixed latency
   always @(negedge clk) begin
      if (rst) begin
         pend      <= 1'b0;
         cd        <= 0;
         resp_done <= 1'b0;
      end else begin
         resp_done <= 1'b0;
         if (pend) begin
            if (cd == 1) begin
               resp_done <= 1'b1;
               pend      <= 1'b0;
            end else begin
               cd <= cd - 1;
            end
         end else if (ps_en_o && resp_on) begin
            pend <= 1'b1;
            cd   <= LAT;
         end
      end
   end

   // monitor: pops expected directions, checks pulse shape and completion
   always @(negedge clk) begin
      cyc <= cyc + 1;
      if (cyc > 100000) begin
         n_chk++;
         n_fail++;
         $display("FAIL watchdog: actual %0d expected %0d", cyc, 100000);
         summary();
      end
      if (rst) begin
         en_prev   <= 1'b0;
         done_prev <= 1'b0;
         cmp_prev  <= 1'b0;
      end else begin
         if (ps_en_o) begin
            en_cnt++;
            check(!en_prev, "R1", "enable held over two cycles", 1, 0);
            if (exp_q.size() == 0) begin
               check(1'b0, "R4/R9", "enable with no step expected", 1, 0);
            end else begin
               bit d;
               d = exp_q.pop_front();
               check(ps_incdec_o == d, "R2", "step direction", ps_incdec_o, d);
            end
         end
         if (complete_o) begin
            cmp_cnt++;
            check(!cmp_prev, "R5", "complete longer than one cycle", 1, 0);
            check(!busy_o, "R5", "busy with complete", busy_o, 0);
            if (!zero_mode)
               check(done_prev, "R5", "complete not one edge after final done step", done_prev, 1);
         end
         en_prev   <= ps_en_o;
         done_prev <= ps_done_i;
         cmp_prev  <= complete_o;
      end
   end

   task automatic pulse_start(input int cnt, input bit dir);
      @(negedge clk);
      start_i    <= 1'b1;
      step_cnt_i <= CNT_W'(cnt);
      step_dir_i <= dir;
      @(negedge clk);
      start_i    <= 1'b0;
   endtask

   task automatic run_req(input int cnt, input bit dir, input string req);
      int e0;
      int c0;
      for (int i = 0; i < cnt; i++) exp_q.push_back(dir);
      e0 = en_cnt;
      c0 = cmp_cnt;
      pulse_start(cnt, dir);
      for (int i = 0; i < cnt * (LAT + 8) + 10; i++) begin
         if (cmp_cnt != c0) break;
         @(negedge clk);
      end
      @(negedge clk);
      exp_pos = dir ? exp_pos + cnt : exp_pos - cnt;
      check(cmp_cnt == c0 + 1, req, "completion count", cmp_cnt - c0, 1);
      check(en_cnt - e0 == cnt, "R3", "enable pulses", en_cnt - e0, cnt);
      check($signed(position_o) == exp_pos, "R7", "position", $signed(position_o), exp_pos);
      check(exp_q.size() == 0, "R3", "unconsumed expected steps", exp_q.size(), 0);
      check(!error_o, "R4", "error after normal handshake", error_o, 0);
   endtask

   initial begin
      rst        = 1'b1;
      start_i    = 1'b0;
      step_cnt_i = '0;
      step_dir_i = 1'b0;
      inj_done   = 1'b0;
      resp_on    = 1'b1;
      zero_mode  = 1'b0;
      exp_pos    = 0;
      repeat (3) @(negedge clk);
      rst <= 1'b0;
      @(negedge clk);
      // R11: reset state
      check(!ps_en_o && !busy_o && !error_o && !complete_o, "R11", "outputs after reset",
            {ps_en_o, busy_o, error_o, complete_o}, 0);
      check(position_o == '0, "R11", "position after reset", position_o, 0);

      // R3 R7: short increment, short decrement
      run_req(3, 1'b1, "R5");
      run_req(5, 1'b0, "R5");
      // R3: the 163-step (about 3 ns) request
      run_req(163, 1'b1, "R5");
      run_req(40, 1'b0, "R5");

      // R6: zero-count request
      begin
         int e0;
         e0 = en_cnt;
         zero_mode = 1'b1;
         @(negedge clk);
         start_i    <= 1'b1;
         step_cnt_i <= '0;
         step_dir_i <= 1'b1;
         @(negedge clk);
         start_i <= 1'b0;
         check(complete_o, "R6", "complete on next edge", complete_o, 1);
         check(!busy_o, "R6", "busy during zero request", busy_o, 0);
         @(negedge clk);
         check(!complete_o, "R6", "complete one cycle", complete_o, 0);
         repeat (20) @(negedge clk);
         check(en_cnt == e0, "R6", "enables for zero request", en_cnt - e0, 0);
         zero_mode = 1'b0;
      end

      // R9: start while busy is ignored
      begin
         int e0;
         int c0;
         e0 = en_cnt;
         c0 = cmp_cnt;
         for (int i = 0; i < 20; i++) exp_q.push_back(1'b1);
         pulse_start(20, 1'b1);
         repeat (50) @(negedge clk);
         check(busy_o, "R9", "busy mid run", busy_o, 1);
         pulse_start(5, 1'b0);
         for (int i = 0; i < 600; i++) begin
            if (cmp_cnt != c0) break;
            @(negedge clk);
         end
         repeat (30) @(negedge clk);
         exp_pos = exp_pos + 20;
         check(en_cnt - e0 == 20, "R9", "enables with ignored start", en_cnt - e0, 20);
         check($signed(position_o) == exp_pos, "R9", "position", $signed(position_o), exp_pos);
         check(!busy_o, "R9", "second request not started", busy_o, 0);
      end

      // R10: stray done while idle
      @(negedge clk);
      inj_done <= 1'b1;
      @(negedge clk);
      inj_done <= 1'b0;
      @(negedge clk);
      check(error_o, "R10", "error after stray done", error_o, 1);
      check($signed(position_o) == exp_pos, "R10", "position after stray done",
            $signed(position_o), exp_pos);

      // R11: reset clears error and position
      rst <= 1'b1;
      repeat (2) @(negedge clk);
      rst <= 1'b0;
      @(negedge clk);
      exp_pos = 0;
      check(!error_o, "R11", "error cleared", error_o, 0);
      check(position_o == '0, "R11", "position cleared", position_o, 0);

      // R8: timeout when done never arrives
      begin
         int e0;
         int c0;
         resp_on = 1'b0;
         e0 = en_cnt;
         c0 = cmp_cnt;
         exp_q.push_back(1'b1);
         pulse_start(3, 1'b1);
         repeat (TMO_CYC + 20) @(negedge clk);
         check(error_o, "R8", "error after timeout", error_o, 1);
         check(!busy_o, "R8", "busy after timeout", busy_o, 0);
         check(en_cnt - e0 == 1, "R8", "enables before abort", en_cnt - e0, 1);
         check(cmp_cnt == c0, "R8", "complete after abort", cmp_cnt - c0, 0);
         check(position_o == '0, "R8", "position after abort", position_o, 0);
         repeat (10) @(negedge clk);
         check(error_o, "R8", "error sticky", error_o, 1);
      end

      summary();
   end

endmodule